// File: doc/BRIEF.md
# Strobed Handshake Output Port

This block is a byte-wide output port with an active-low two-wire handshake to a peripheral. The CPU writes a byte over a small register interface (select, write, read, one address bit and a data bus). The byte is latched onto the port pins and the full indicator goes low, which tells the peripheral that fresh data is waiting. The peripheral pulses its acknowledge line low while it takes the byte. When that line returns high, the port marks the buffer empty and, if interrupts are enabled, raises an interrupt request. The CPU's next data write clears the request and fills the buffer again.

The acknowledge line is asynchronous to the CPU clock. It passes through a two-flop synchronizer, and only its rising edge counts as a completion. Software can also poll a status register instead of using the interrupt.

Top module: `hs_out_port`

## Requirements
- R1: After reset, full_n is 1, irq is 0, port_q is 0x00, the interrupt enable is 0, and a status read returns 0x00.
- R2: A write with cs=1, wr=1, addr=0 loads wdata onto port_q and drives full_n low at the next rising clock edge. A write with cs=0 changes nothing. port_q changes only on a data write.
- R3: When full_n is low and ack_n rises, full_n returns high at the third rising clock edge after ack_n goes high (two synchronizer stages plus one register), and not before.
- R4: At the same edge as R3, irq is set to 1 if the interrupt enable is 1. It stays 0 if the enable is 0.
- R5: A data write clears irq at the next edge.
- R6: A data write while full_n is already low replaces the latched byte. full_n stays low and irq stays 0.
- R7: An ack_n pulse while full_n is high has no effect. full_n stays high and irq stays 0.
- R8: A write with addr=1 sets the interrupt enable to wdata bit 0. Writing 0 clears irq at the same edge, so irq is never 1 while the enable is 0.
- R9: A read with cs=1, rd=1, addr=1 returns status {5'b0, enable (bit 2), irq (bit 1), full (bit 0, the inverse of full_n)}. A read with addr=0 returns the latched byte. rdata is 0x00 when no read is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Register select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | 1 | 0 = data byte, 1 = control/status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| port_q | output | 8 | Latched byte driven to the peripheral |
| full_n | output | 1 | Low while a byte is waiting |
| ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all 256 byte values through a full write/acknowledge cycle. The enable alternates in pairs, so every value is seen with the interrupt both armed and disarmed. In each cycle, full_n is sampled one edge before and exactly at the expected release, which separates a correct synchronizer latency from one that is a stage too short or too long.

Several directed patterns then cover the corners:
- back-to-back writes without an acknowledge, which tells overwrite apart from queuing;
- an acknowledge pulse on an empty buffer, which tells level sensing apart from edge sensing gated by the full flag;
- clearing the enable while a request is pending;
- a write with the select low.

// File: rtl/hs_out_pkg.sv
package hs_out_pkg;
  localparam int STAT_W = 3;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  // status field order: enable at bit 2, request at bit 1, full at bit 0
  function automatic logic [STAT_W-1:0] pack_status(logic ie, logic req, logic full);
    return {ie, req, full};
  endfunction

  // next interrupt state: a data write or an enable clear wins over a completion
  function automatic logic next_irq(logic cur, logic wr_dat, logic wr_ctl,
                                    logic ie_new, logic ie_cur, logic done);
    logic n;
    n = cur;
    if (done && ie_cur) n = 1'b1;
    if (wr_ctl && !ie_new) n = 1'b0;
    if (wr_dat) n = 1'b0;
    return n;
  endfunction
endpackage

// File: rtl/hs_ack_sync.sv
module hs_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n,
  output logic ack_rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= ack_n;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[i] <= 1'b1;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain[STAGES-1];
  end

  assign ack_rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/hs_out_latch.sv
module hs_out_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/hs_out_ctrl.sv
module hs_out_ctrl
  import hs_out_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_data,
  input  logic wr_ctrl,
  input  logic ie_din,
  input  logic ack_rise,
  output logic full,
  output logic irq,
  output logic ie,
  output logic ack_done
);
  assign ack_done = ack_rise & full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      irq  <= 1'b0;
      ie   <= 1'b0;
    end else begin
      if (wr_data)       full <= 1'b1;
      else if (ack_done) full <= 1'b0;
      irq <= next_irq(irq, wr_data, wr_ctrl, ie_din, ie, ack_done);
      if (wr_ctrl) ie <= ie_din;
    end
  end
endmodule

// File: rtl/hs_out_port.sv
module hs_out_port
  import hs_out_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          wr,
  input  logic          rd,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] port_q,
  output logic          full_n,
  input  logic          ack_n,
  output logic          irq
);
  localparam int PAD = DW - STAT_W;

  logic wr_data, wr_ctrl, rd_any;
  logic ack_rise, ack_done, full, ie;

  assign wr_data = cs & wr & (reg_sel_e'(addr) == SEL_DATA);
  assign wr_ctrl = cs & wr & (reg_sel_e'(addr) == SEL_CTRL);
  assign rd_any  = cs & rd;

  hs_ack_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .ack_rise(ack_rise)
  );

  hs_out_latch #(.DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(wr_data), .din(wdata), .q(port_q)
  );

  hs_out_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
    .ie_din(wdata[0]), .ack_rise(ack_rise), .full(full), .irq(irq),
    .ie(ie), .ack_done(ack_done)
  );

  assign full_n = ~full;

  always_comb begin
    rdata = '0;
    if (rd_any) begin
      if (reg_sel_e'(addr) == SEL_CTRL) rdata = {{PAD{1'b0}}, pack_status(ie, irq, full)};
      else                              rdata = port_q;
    end
  end
endmodule

// File: rtl/hs_out_port_chk.sv
module hs_out_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_data,
  input logic          wr_ctrl,
  input logic          ack_done,
  input logic          ie,
  input logic          full_n,
  input logic          irq,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] port_q
);
  assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (!full_n && port_q == $past(wdata)));

  assert_latch_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(port_q));

  assert_empty_only_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_n) |-> $past(ack_done));

  assert_irq_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && ie && !wr_data && !wr_ctrl) |=> irq);

  assert_write_clears_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !irq);

  assert_empty_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_n && !wr_data) |=> (full_n && !$rose(irq)));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie);
endmodule

bind hs_out_port hs_out_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
  .ack_done(ack_done), .ie(ie), .full_n(full_n), .irq(irq),
  .wdata(wdata), .port_q(port_q)
);

// File: tb/hs_out_port_bench.sv
`timescale 1ns/1ps
module hs_out_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, port_q;
  logic       full_n, irq;
  logic       ack_n = 1'b1;
  int         checks = 0;
  int         errors = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  hs_out_port u_hs_out_port (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .port_q(port_q), .full_n(full_n),
    .ack_n(ack_n), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic cpu_write(logic a, logic [7:0] d, logic sel = 1'b1);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic cpu_read(logic a, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  // pulse ack_n; if a completion is expected, check the release edge exactly
  task automatic ack_pulse(bit expect_done, string req);
    @(negedge clk);
    ack_n = 1'b0;
    repeat (3) @(negedge clk);
    ack_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (expect_done) chk({req, " still full after two edges"}, {7'b0, full_n}, 8'h0);
    @(negedge clk);
    chk({req, " empty after third edge"}, {7'b0, full_n}, 8'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 full_n", {7'b0, full_n}, 8'h1);
    chk("R1 irq", {7'b0, irq}, 8'h0);
    chk("R1 port_q", port_q, 8'h00);
    cpu_read(1'b1, rv);
    chk("R1 status", rv, 8'h00);
    // R9 idle rdata
    chk("R9 idle rdata", rdata, 8'h00);

    // R2 write with select low is ignored
    cpu_write(1'b0, 8'h5A, 1'b0);
    chk("R2 cs low port_q", port_q, 8'h00);
    chk("R2 cs low full_n", {7'b0, full_n}, 8'h1);

    // R7 ack on empty buffer with enable set
    cpu_write(1'b1, 8'h01);
    ack_pulse(1'b0, "R7");
    chk("R7 irq", {7'b0, irq}, 8'h0);

    // sweep all byte values: R2 R3 R4 R5 R9
    for (int v = 0; v < 256; v++) begin
      logic ie_bit;
      logic [7:0] vb;
      vb = 8'(v);
      ie_bit = vb[1];
      cpu_write(1'b0, vb);
      chk("R2 port_q", port_q, vb);
      chk("R2 full_n", {7'b0, full_n}, 8'h0);
      chk("R5 irq cleared by write", {7'b0, irq}, 8'h0);
      cpu_write(1'b1, {7'b0, ie_bit});
      cpu_read(1'b0, rv);
      chk("R9 data read", rv, vb);
      cpu_read(1'b1, rv);
      chk("R9 status full", rv, {5'b0, ie_bit, 1'b0, 1'b1});
      ack_pulse(1'b1, "R3");
      chk("R4 irq after ack", {7'b0, irq}, {7'b0, ie_bit});
      cpu_read(1'b1, rv);
      chk("R9 status done", rv, {5'b0, ie_bit, ie_bit, 1'b0});
    end

    // R8 clearing enable drops a pending request
    cpu_write(1'b1, 8'h01);
    cpu_write(1'b0, 8'hC3);
    ack_pulse(1'b1, "R8");
    chk("R8 irq pending", {7'b0, irq}, 8'h1);
    cpu_write(1'b1, 8'h00);
    chk("R8 irq cleared", {7'b0, irq}, 8'h0);
    chk("R8 full_n unchanged", {7'b0, full_n}, 8'h1);

    // R6 overwrite while full
    cpu_write(1'b1, 8'h01);
    cpu_write(1'b0, 8'h11);
    cpu_write(1'b0, 8'h22);
    chk("R6 port_q", port_q, 8'h22);
    chk("R6 full_n", {7'b0, full_n}, 8'h0);
    chk("R6 irq", {7'b0, irq}, 8'h0);
    ack_pulse(1'b1, "R6");
    chk("R6 single completion irq", {7'b0, irq}, 8'h1);
    ack_pulse(1'b0, "R7 second pulse");
    chk("R7 irq unchanged", {7'b0, irq}, 8'h1);
    chk("R2 port_q held", port_q, 8'h22);

    report();
    $finish;
  end
endmodule